// File: doc/BRIEF.md
# Multiplexed Six-Button Gamepad Port Unit

This unit is a small memory-mapped I/O block. It serves three identical gamepad ports on a byte-wide register bus. Each port takes a 12-bit live button word as a plain input. Each port holds three registers: a direction mask, a serial-control value and a read latch. It also holds a 3-bit phase counter. The CPU writes the data register to drive the select line, which is bit 6 of the masked write byte. Every change of that bit advances the port's phase counter. The new phase then chooses which button bits are merged into the byte that the CPU reads back. This lets a six-button pad be scanned through a 6-bit read window over successive select toggles.

Reads are registered. The result appears on `rd_data_o` one cycle after `rd_en_i`, with `rd_valid_o` high for that cycle. A read at an even address is redirected to the register at the next odd address. Writes take effect only at the exact odd address of a register. A port whose select line has not toggled for 1.5 ms drops back to phase 0. The block measures this with a per-port prescaler derived from the `CLK_HZ` parameter.

Top module: `pad_mux_io`

## Requirements
- R1: After reset, every data latch and direction mask reads 0x00, every serial-control register reads 0x02, and every phase counter is 0, so the first select toggle produces phase 1.
- R2: The version register at 0x01 always reads 0xA0. Every read returns its byte in `rd_data_o[7:0]`, with `rd_data_o[15:8]` zero and `rd_valid_o` high exactly in the cycle after `rd_en_i`. `rd_valid_o` is low after a cycle without `rd_en_i`.
- R3: A read at an even address returns the register at that address plus one.
- R4: The direction masks sit at 0x09, 0x0B and 0x0D for ports 0, 1 and 2, and they read back as written. The serial-control registers sit at 0x13, 0x19 and 0x1F. A write to one of them stores only bits 7..3, and a read returns the stored value with bit 1 forced to 1.
- R5: The data registers sit at 0x03, 0x05 and 0x07. A data write whose masked value (write byte AND direction mask) keeps bit 6 equal to the latch's bit 6 stores only the masked value, with no button bits and no phase change.
- R6: A data write whose masked bit 6 differs from the latch's bit 6 first increments the phase. It then stores the masked value ORed with a 6-bit field, where button word bits 0..11 are Up, Down, Left, Right, C, B, A, Start, Mode, Z, Y, X. The field by phase is:
  - phases 1 and 7: {Start, A, 0, 0, Down, Up};
  - phases 2 and 6: button bits 5..0;
  - phase 3: {Start, A, 0000};
  - phase 4: {B, C, X, Y, Z, Mode};
  - phase 5: {Start, A, 1111}.
- R7: After producing the phase 7 value, the counter returns to 0, so the eighth toggle of a run produces phase 1 again.
- R8: A port's phase counter clears to 0 once 1.5 ms passes with no select toggle. That span is 15 ticks of CLK_HZ/10000 cycles, and each toggle restarts it. The read latch is not changed by this timeout.
- R9: Writes to unmapped or even addresses change no register. Reads of unmapped addresses return 0x00.
- R10: The ports are independent: a write to one port's registers changes no other port's latch, mask or phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_i | input | NUM_PORTS x 12 | Live button words, port p in btn_i[p] |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write byte |
| rd_en_i | input | 1 | Read strobe |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 16 | Read result, register byte in bits 7..0 |

## Verification
The phase walk is run over two full eight-toggle cycles, each with a different button word. The words are chosen so that Start/A, C/B and the direction and extra-button nibbles hold distinct bit values. A mis-routed or swapped field therefore shows up as a wrong value in a specific phase, and the eighth toggle separates a correct wrap from a counter that runs past 7. Data writes that keep bit 6 unchanged, or that have bit 6 masked off, separate "no toggle" from "toggle". Idle gaps well below and well above 1.5 ms show whether the timeout fires at all and whether it fires too early. A second port is toggled while the first is watched, to catch crosstalk between ports.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;
  localparam int BYTE_W    = 8;
  localparam int BTN_W     = 12;
  localparam int PHASE_W   = 3;
  localparam int FIELD_W   = 6;
  localparam int SEL_BIT   = 6;
  localparam logic [BYTE_W-1:0] VERSION_VAL = 8'hA0;
  localparam logic [BYTE_W-1:0] SCTL_KEEP   = 8'hF8;
  localparam logic [BYTE_W-1:0] SCTL_FORCE  = 8'h02;

  typedef struct packed {
    logic               ok;
    logic [FIELD_W-1:0] bits;
  } field_t;

  // button field merged into the read latch for a given phase
  function automatic field_t phase_field(logic [PHASE_W-1:0] ph, logic [BTN_W-1:0] b);
    field_t f;
    f.ok = 1'b1;
    unique case (ph)
      3'd1, 3'd7: f.bits = {b[7:6], 2'b00, b[1:0]};
      3'd2, 3'd6: f.bits = b[5:0];
      3'd3:       f.bits = {b[7:6], 4'b0000};
      3'd4:       f.bits = {b[5:4], b[11:8]};
      3'd5:       f.bits = {b[7:6], 4'b1111};
      default: begin
        f.ok   = 1'b0;
        f.bits = '0;
      end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/pad_mux_dec.sv
module pad_mux_dec #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 6,
  parameter int VER_ADDR  = 'h01,
  parameter int DATA_BASE = 'h03,
  parameter int DATA_STEP = 2,
  parameter int CTRL_BASE = 'h09,
  parameter int CTRL_STEP = 2,
  parameter int SCTL_BASE = 'h13,
  parameter int SCTL_STEP = 6
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 ver_hit_o,
  output logic [NUM_PORTS-1:0] data_hit_o,
  output logic [NUM_PORTS-1:0] ctrl_hit_o,
  output logic [NUM_PORTS-1:0] sctl_hit_o
);
  assign ver_hit_o = (addr_i == ADDR_W'(VER_ADDR));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign data_hit_o[p] = (addr_i == ADDR_W'(DATA_BASE + p * DATA_STEP));
    assign ctrl_hit_o[p] = (addr_i == ADDR_W'(CTRL_BASE + p * CTRL_STEP));
    assign sctl_hit_o[p] = (addr_i == ADDR_W'(SCTL_BASE + p * SCTL_STEP));
  end
endmodule

// File: rtl/pad_mux_idle_timer.sv
module pad_mux_idle_timer #(
  parameter int TICK_CYC = 5000,
  parameter int TICK_CNT = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expire_o
);
  localparam int PW = $clog2(TICK_CYC) + 1;
  localparam int TW = $clog2(TICK_CNT) + 1;

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;
  logic          pre_last, tick_last;

  assign pre_last  = (pre_q == PW'(TICK_CYC - 1));
  assign tick_last = (tick_q == TW'(TICK_CNT - 1));
  assign expire_o  = !restart_i && pre_last && tick_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (restart_i) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (pre_last) begin
      pre_q  <= '0;
      tick_q <= tick_last ? '0 : tick_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pad_mux_port.sv
module pad_mux_port
  import pad_mux_pkg::*;
#(
  parameter int TICK_CYC = 5000,
  parameter int TICK_CNT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BTN_W-1:0]  btn_i,
  input  logic              data_we_i,
  input  logic              ctrl_we_i,
  input  logic              sctl_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] sctl_o
);
  logic [BYTE_W-1:0]  data_q, ctrl_q, sctl_q, masked;
  logic [PHASE_W-1:0] phase_q, phase_nxt;
  logic               toggle, expire;
  field_t             fld;

  assign masked    = wdata_i & ctrl_q;
  assign toggle    = data_we_i && (masked[SEL_BIT] != data_q[SEL_BIT]);
  assign phase_nxt = phase_q + 1'b1;
  assign fld       = phase_field(phase_nxt, btn_i);

  pad_mux_idle_timer #(
    .TICK_CYC (TICK_CYC),
    .TICK_CNT (TICK_CNT)
  ) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (toggle),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      phase_q <= '0;
    end else if (toggle) begin
      if (fld.ok) begin
        data_q  <= masked | BYTE_W'(fld.bits);
        phase_q <= (phase_nxt == '1) ? '0 : phase_nxt;
      end else begin
        data_q  <= '0;
        phase_q <= '0;
      end
    end else begin
      if (data_we_i) data_q <= masked;
      if (expire)    phase_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sctl_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i;
      if (sctl_we_i) sctl_q <= wdata_i & SCTL_KEEP;
    end
  end

  assign data_o = data_q;
  assign ctrl_o = ctrl_q;
  assign sctl_o = sctl_q | SCTL_FORCE;
endmodule

// File: rtl/pad_mux_io.sv
module pad_mux_io
  import pad_mux_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 6,
  parameter int CLK_HZ    = 50_000_000,
  parameter int IDLE_TICKS = 15
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORTS-1:0][BTN_W-1:0]  btn_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             wr_en_i,
  input  logic [BYTE_W-1:0]                wr_data_i,
  input  logic                             rd_en_i,
  output logic                             rd_valid_o,
  output logic [2*BYTE_W-1:0]              rd_data_o
);
  // 100 us prescale tick; IDLE_TICKS of them form the idle window
  localparam int TICK_CYC = (CLK_HZ / 10_000 < 2) ? 2 : CLK_HZ / 10_000;

  logic                 w_ver, r_ver;
  logic [NUM_PORTS-1:0] w_data, w_ctrl, w_sctl;
  logic [NUM_PORTS-1:0] r_data, r_ctrl, r_sctl;
  logic [ADDR_W-1:0]    rd_addr;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] data_v, ctrl_v, sctl_v;
  logic [BYTE_W-1:0]    rd_byte;
  logic                 rd_valid_q;
  logic [BYTE_W-1:0]    rd_byte_q;

  assign rd_addr = {addr_i[ADDR_W-1:1], 1'b1};

  pad_mux_dec #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_wdec (
    .addr_i     (addr_i),
    .ver_hit_o  (w_ver),
    .data_hit_o (w_data),
    .ctrl_hit_o (w_ctrl),
    .sctl_hit_o (w_sctl)
  );

  pad_mux_dec #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_rdec (
    .addr_i     (rd_addr),
    .ver_hit_o  (r_ver),
    .data_hit_o (r_data),
    .ctrl_hit_o (r_ctrl),
    .sctl_hit_o (r_sctl)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pad_mux_port #(
      .TICK_CYC (TICK_CYC),
      .TICK_CNT (IDLE_TICKS)
    ) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .btn_i     (btn_i[p]),
      .data_we_i (wr_en_i && w_data[p]),
      .ctrl_we_i (wr_en_i && w_ctrl[p]),
      .sctl_we_i (wr_en_i && w_sctl[p]),
      .wdata_i   (wr_data_i),
      .data_o    (data_v[p]),
      .ctrl_o    (ctrl_v[p]),
      .sctl_o    (sctl_v[p])
    );
  end

  always_comb begin
    rd_byte = r_ver ? VERSION_VAL : '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (r_data[p]) rd_byte = rd_byte | data_v[p];
      if (r_ctrl[p]) rd_byte = rd_byte | ctrl_v[p];
      if (r_sctl[p]) rd_byte = rd_byte | sctl_v[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_byte_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_byte_q <= rd_byte;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = {{BYTE_W{1'b0}}, rd_byte_q};

  // w_ver is decoded for completeness of the map; version is read-only
  logic unused_w_ver;
  assign unused_w_ver = w_ver;
endmodule

// File: rtl/pad_mux_io_chk.sv
module pad_mux_io_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [7:0]        wr_data_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic [15:0]       rd_data_o
);
  logic [ADDR_W-1:0] odd_a;
  logic              is_sctl, is_ver, is_map;

  assign odd_a   = {addr_i[ADDR_W-1:1], 1'b1};
  assign is_ver  = (int'(odd_a) == 'h01);
  assign is_sctl = (int'(odd_a) inside {'h13, 'h19, 'h1F});
  assign is_map  = (int'(odd_a) inside {'h01, 'h03, 'h05, 'h07, 'h09, 'h0B, 'h0D, 'h13, 'h19, 'h1F});

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R2
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_data_o[15:8] == 8'h00); // R2
  AST_VERSION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_ver) |=> rd_data_o[7:0] == 8'hA0); // R3
  AST_SCTL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_sctl) |=> rd_data_o[2:0] == 3'b010); // R4
  AST_CTRL_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) == 'h09) ##1 (rd_en_i && !wr_en_i && int'(addr_i) == 'h09)
      |=> rd_data_o[7:0] == $past(wr_data_i, 2)); // R4
  AST_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !is_map) |=> rd_data_o[7:0] == 8'h00); // R9
endmodule

bind pad_mux_io pad_mux_io_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/sim_pad_mux_io.sv
module sim_pad_mux_io;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 100_000;
  localparam int IDLE_CYC   = 15 * (CLK_HZ / 10_000);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0][11:0]  btn = '0;
  logic [5:0]        addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = '0;
  logic              rd_en = 1'b0;
  logic              rd_valid;
  logic [15:0]       rd_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  // bench model state
  logic [7:0] m_ctrl [3];
  logic [7:0] m_lat  [3];
  int         m_cnt  [3];
  int         m_last [3];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pad_mux_io #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .btn_i      (btn),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rd_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read result: actual %h expected none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  function automatic logic [5:0] fld(int k, logic [11:0] b);
    case (k)
      1, 7:    return {b[7:6], 2'b00, b[1:0]};
      2, 6:    return b[5:0];
      3:       return {b[7:6], 4'b0000};
      4:       return {b[5:4], b[11:8]};
      5:       return {b[7:6], 4'b1111};
      default: return 6'h00;
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back({8'h00, e});
    tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_ctrl(input int p, input logic [7:0] d);
    wr(6'(9 + 2*p), d);
    m_ctrl[p] = d;
  endtask

  // data write with model update, then read back
  task automatic dwr(input int p, input logic [7:0] d, input string t);
    logic [7:0] mk;
    int el;
    el = (cyc + 1) - m_last[p];
    if (el > IDLE_CYC) m_cnt[p] = 0;
    mk = d & m_ctrl[p];
    if (mk[6] != m_lat[p][6]) begin
      m_cnt[p]++;
      m_lat[p] = mk | {2'b00, fld(m_cnt[p], btn[p])};
      if (m_cnt[p] == 7) m_cnt[p] = 0;
      m_last[p] = cyc + 1;
    end else begin
      m_lat[p] = mk;
    end
    wr(6'(3 + 2*p), d);
    rd(6'(3 + 2*p), m_lat[p], t);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      m_ctrl[p] = 8'h00; m_lat[p] = 8'h00; m_cnt[p] = 0; m_last[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    idle(1);

    // reset state
    rd(6'h03, 8'h00, "R1 data0 reset");
    rd(6'h07, 8'h00, "R1 data2 reset");
    rd(6'h09, 8'h00, "R1 ctrl0 reset");
    rd(6'h1F, 8'h02, "R1 sctl2 reset");
    rd(6'h01, 8'hA0, "R2 version");
    rd(6'h00, 8'hA0, "R3 even version");
    rd(6'h11, 8'h00, "R9 unmapped read");

    // control and serial-control
    set_ctrl(0, 8'h40);
    rd(6'h09, 8'h40, "R4 ctrl0 readback");
    rd(6'h08, 8'h40, "R3 even ctrl0");
    wr(6'h13, 8'hFF);
    rd(6'h13, 8'hFA, "R4 sctl0 keep 7..3");
    wr(6'h19, 8'h05);
    rd(6'h18, 8'h02, "R4 sctl1 low bits dropped");

    // no-toggle writes
    btn[0] = 12'hA5C;
    dwr(0, 8'h3F, "R5 sel masked to zero");
    set_ctrl(0, 8'h7F);
    dwr(0, 8'h3F, "R5 no toggle stores masked");
    dwr(0, 8'h15, "R5 no toggle second value");

    // two full phase walks, distinct button words
    for (int i = 0; i < 8; i++)
      dwr(0, (i % 2 == 0) ? 8'h40 : 8'h00, "R6 R7 walk A");
    btn[0] = 12'h5A3;
    for (int i = 0; i < 8; i++)
      dwr(0, (i % 2 == 0) ? 8'h40 : 8'h00, "R6 R7 walk B");
    dwr(0, 8'h41, "R5 same sel no toggle");

    // independence
    btn[1] = 12'hC39;
    set_ctrl(1, 8'h40);
    dwr(1, 8'h40, "R10 port1 phase1");
    rd(6'h03, m_lat[0], "R10 port0 untouched");
    rd(6'h0B, 8'h40, "R10 ctrl1");
    rd(6'h09, 8'h7F, "R10 ctrl0 untouched");

    // ignored writes
    wr(6'h08, 8'hFF);
    rd(6'h09, 8'h7F, "R9 even write ignored");
    wr(6'h21, 8'hFF);
    rd(6'h21, 8'h00, "R9 unmapped write ignored");
    wr(6'h02, 8'h00);
    rd(6'h03, m_lat[0], "R9 even data write ignored");

    // idle timeout
    idle(IDLE_CYC + 20);
    rd(6'h03, m_lat[0], "R8 latch kept after timeout");
    dwr(0, (m_lat[0][6]) ? 8'h00 : 8'h40, "R8 restart at phase1");
    dwr(0, (m_lat[0][6]) ? 8'h00 : 8'h40, "R8 phase2");
    idle(IDLE_CYC - 20);
    dwr(0, (m_lat[0][6]) ? 8'h00 : 8'h40, "R8 short gap keeps phase");
    idle(IDLE_CYC + 20);
    dwr(0, (m_lat[0][6]) ? 8'h00 : 8'h40, "R8 long gap clears phase");

    idle(3);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing reads: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule